// File: doc/BRIEF.md
# Controller Reset Sequencer

This block gathers every source that can reset a storage host-interface controller and turns them into one sequenced reset of the controller core. Software starts a subsystem reset by writing a 32-bit key to a dedicated control register, and starts a controller reset by clearing the enable bit in the configuration register. Hardware sources come in as level inputs: conventional (hot, warm or cold) reset, transaction-layer link down, and function-level reset.

When any source fires, the core reset output is raised for a fixed window, and the ready status drops. The block records which sources caused the latest reset. A subsystem reset also sets a separate sticky flag that only the block's own power-on reset clears. The configuration register also holds the memory page size field. Its value sets the page shift given to the rest of the controller, and any encoding above the supported maximum is refused.

Top module: `ctrl_reset_unit`

## Requirements
- R1: A write of exactly 32'h4E564D65 to the subsystem control register (offset 20h) starts a reset and sets subsys_flag_o and cause bit 0 on the next clock edge.
- R2: A write of any other value to offset 20h has no effect on any output, and a read of offset 20h returns 0.
- R3: Each of conv_rst_i, link_down_i and func_rst_i, when high at a clock edge, raises core_rst_o after that edge. The input is sampled as a level on every cycle.
- R4: A write to offset 14h that clears bit 0 while enable is 1 starts a reset. A write that sets bit 0 while enable is 0 starts none.
- R5: core_rst_o stays high for exactly WINDOW cycles (default 16) after the last edge at which any cause was present. A cause that arrives during the window restarts the full window.
- R6: ready_o falls on the edge that samples a cause. It rises one cycle after core_rst_o has fallen, and only if enable is 1. When no reset is running, it rises one cycle after enable is set.
- R7: cause_o is loaded with the set of causes present at each triggering edge and holds it otherwise. The bit order is 0 subsystem, 1 conventional, 2 link down, 3 function-level, 4 enable falling.
- R8: subsys_flag_o, once set, stays set through every controller reset and clears only on rst_ni.
- R9: The configuration register at offset 14h has enable in bit 0 and page size in bits 10:7, and it reads back in those positions with all other bits 0. Any cause other than the enable-falling write clears both fields.
- R10: A page size above MPS_MAX is not applied, and mps_err_o is set. A valid page size is stored, mps_err_o is cleared, and page_shift_o equals 12 plus the stored size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| conv_rst_i | input | 1 | Conventional reset request, level |
| link_down_i | input | 1 | Link-down indication, level |
| func_rst_i | input | 1 | Function-level reset request, level |
| core_rst_o | output | 1 | Reset to the controller core |
| ready_o | output | 1 | Controller ready status |
| cause_o | output | 5 | Causes of the latest reset |
| subsys_flag_o | output | 1 | Sticky subsystem-reset flag |
| enable_o | output | 1 | Current enable bit |
| page_shift_o | output | 6 | log2 of memory page size in bytes |
| mps_err_o | output | 1 | Last page-size write was refused |

## Verification
The hardest case to reach is the overlap of causes: a second source arriving in the last cycles of a running window, or at the same edge as a configuration write or as the enable-falling write. Overlap is what shows whether the window restarts, which cause set is recorded, and whether the configuration clear wins over the write. Directed sequences place a link-down pulse near the end of a window, and place a key write, or an enable-falling write, in the same cycle as an external cause. A long random phase then applies rare pulses from each source together with frequent register writes. Every output is compared against a cycle model in the bench on every cycle.

// File: rtl/crst_pkg.sv
package crst_pkg;
  localparam int unsigned NCAUSE = 5;
  typedef enum int unsigned {
    C_SUBSYS = 0,
    C_CONV   = 1,
    C_LINK   = 2,
    C_FUNC   = 3,
    C_ENFALL = 4
  } cause_e;
  localparam logic [31:0] SUBSYS_KEY = 32'h4E564D65;
  localparam int unsigned OFS_CFG = 'h14;
  localparam int unsigned OFS_SSR = 'h20;
  localparam int unsigned MPS_LSB = 7;
  localparam int unsigned PAGE_BASE_SHIFT = 12;
endpackage

// File: rtl/crst_regs.sv
module crst_regs
  import crst_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MPS_W   = 4,
  parameter int unsigned MPS_MAX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              hw_clr_i,
  output logic              en_o,
  output logic [MPS_W-1:0]  mps_o,
  output logic              mps_err_o,
  output logic              key_hit_o,
  output logic              en_fall_o,
  output logic [31:0]       rdata_o
);
  logic             en_q;
  logic [MPS_W-1:0] mps_q;
  logic             err_q;
  logic             wr_cfg, wr_ssr, mps_ok;
  logic [MPS_W-1:0] mps_new;

  assign wr_cfg  = we_i && (addr_i == ADDR_W'(OFS_CFG));
  assign wr_ssr  = we_i && (addr_i == ADDR_W'(OFS_SSR));
  assign mps_new = wdata_i[MPS_LSB +: MPS_W];
  assign mps_ok  = (32'(mps_new) <= MPS_MAX);

  assign key_hit_o = wr_ssr && (wdata_i == SUBSYS_KEY);
  assign en_fall_o = wr_cfg && en_q && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      mps_q <= '0;
      err_q <= 1'b0;
    end else if (hw_clr_i) begin
      en_q  <= 1'b0;
      mps_q <= '0;
    end else if (wr_cfg) begin
      en_q  <= wdata_i[0];
      err_q <= !mps_ok;
      if (mps_ok) mps_q <= mps_new;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CFG)) begin
      rdata_o[0]                = en_q;
      rdata_o[MPS_LSB +: MPS_W] = mps_q;
    end
  end

  assign en_o      = en_q;
  assign mps_o     = mps_q;
  assign mps_err_o = err_q;

  a_r10_mps_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(mps_q) <= MPS_MAX);
  a_r9_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr_i |=> !en_q && (mps_q == '0));
  a_r10_bad_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !mps_ok && !hw_clr_i) |=> $stable(mps_q) && err_q);
endmodule

// File: rtl/crst_seq.sv
module crst_seq #(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic en_i,
  output logic core_rst_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (trig_i)            cnt_q <= CNT_W'(WINDOW);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      rdy_q <= !trig_i && en_i && (cnt_q == '0);
    end
  end

  assign core_rst_o = (cnt_q != '0);
  assign ready_o    = rdy_q;

  a_r3_trig_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> core_rst_o);
  a_r5_window_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && cnt_q == CNT_W'(1)) |=> !core_rst_o);
  a_r6_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !ready_o);
  a_r6_ready_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(en_i) && !$past(core_rst_o));
  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !core_rst_o);
endmodule

// File: rtl/crst_cause.sv
module crst_cause
  import crst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCAUSE-1:0] trig_i,
  output logic [NCAUSE-1:0] cause_o,
  output logic              subsys_flag_o
);
  logic [NCAUSE-1:0] cause_q;
  logic              flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (|trig_i)          cause_q <= trig_i;
      if (trig_i[C_SUBSYS]) flag_q  <= 1'b1;
    end
  end

  assign cause_o       = cause_q;
  assign subsys_flag_o = flag_q;

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q);
  a_r1_flag_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(trig_i[C_SUBSYS]));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|trig_i) |=> $stable(cause_q));
endmodule

// File: rtl/ctrl_reset_unit.sv
module ctrl_reset_unit
  import crst_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned WINDOW  = 16,
  parameter int unsigned MPS_W   = 4,
  parameter int unsigned MPS_MAX = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              conv_rst_i,
  input  logic              link_down_i,
  input  logic              func_rst_i,
  output logic              core_rst_o,
  output logic              ready_o,
  output logic [4:0]        cause_o,
  output logic              subsys_flag_o,
  output logic              enable_o,
  output logic [5:0]        page_shift_o,
  output logic              mps_err_o
);
  logic [NCAUSE-1:0] trig;
  logic              key_hit, en_fall, hw_clr, en;
  logic [MPS_W-1:0]  mps;

  assign trig[C_SUBSYS] = key_hit;
  assign trig[C_CONV]   = conv_rst_i;
  assign trig[C_LINK]   = link_down_i;
  assign trig[C_FUNC]   = func_rst_i;
  assign trig[C_ENFALL] = en_fall;
  // every cause except the enable-falling write wipes the configuration
  assign hw_clr = |trig[C_FUNC:C_SUBSYS];

  crst_regs #(.ADDR_W(ADDR_W), .MPS_W(MPS_W), .MPS_MAX(MPS_MAX)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hw_clr_i  (hw_clr),
    .en_o      (en),
    .mps_o     (mps),
    .mps_err_o (mps_err_o),
    .key_hit_o (key_hit),
    .en_fall_o (en_fall),
    .rdata_o   (reg_rdata_o)
  );

  crst_seq #(.WINDOW(WINDOW)) u_seq (
    .clk_i, .rst_ni,
    .trig_i     (|trig),
    .en_i       (en),
    .core_rst_o (core_rst_o),
    .ready_o    (ready_o)
  );

  crst_cause u_cause (
    .clk_i, .rst_ni,
    .trig_i        (trig),
    .cause_o       (cause_o),
    .subsys_flag_o (subsys_flag_o)
  );

  assign enable_o     = en;
  assign page_shift_o = 6'(PAGE_BASE_SHIFT) + 6'(mps);

  a_r3_rise_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(|trig));
  a_r7_cause_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (cause_o != '0));
endmodule

// File: tb/ctrl_reset_unit_tb_top.sv
module ctrl_reset_unit_tb_top;
  localparam int unsigned W  = 16;
  localparam int unsigned MX = 10;
  localparam logic [31:0] KEY = 32'h4E564D65;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, conv = 1'b0, link = 1'b0, fr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic core_rst, ready, sflag, en_o, merr;
  logic [4:0] cause;
  logic [5:0] pshift;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctrl_reset_unit #(.WINDOW(W), .MPS_MAX(MX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .conv_rst_i(conv),
    .link_down_i(link), .func_rst_i(fr), .core_rst_o(core_rst),
    .ready_o(ready), .cause_o(cause), .subsys_flag_o(sflag),
    .enable_o(en_o), .page_shift_o(pshift), .mps_err_o(merr));

  // cycle model built from the requirements
  int   m_cnt;
  logic m_rdy, m_en, m_err, m_flag;
  logic [3:0] m_mps;
  logic [4:0] m_cause;

  function automatic logic [4:0] causes_now();
    logic [4:0] t;
    t[0] = we && addr == 12'h020 && wdata == KEY;
    t[1] = conv; t[2] = link; t[3] = fr;
    t[4] = we && addr == 12'h014 && m_en && !wdata[0];
    return t;
  endfunction

  function automatic logic [31:0] exp_rdata();
    return (addr == 12'h014) ? {21'b0, m_mps, 6'b0, m_en} : 32'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rdy = 0; m_en = 0; m_err = 0; m_flag = 0; m_mps = 0; m_cause = 0;
    end else begin
      logic [4:0] t;
      t = causes_now();
      m_rdy = !(|t) && m_en && m_cnt == 0;
      if (|t) m_cnt = W; else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (|t) m_cause = t;
      if (t[0]) m_flag = 1;
      if (|t[3:0]) begin m_en = 0; m_mps = 0; end
      else if (we && addr == 12'h014) begin
        m_en  = wdata[0];
        m_err = wdata[10:7] > MX;
        if (wdata[10:7] <= MX) m_mps = wdata[10:7];
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R5", "core_rst", 32'(core_rst), 32'(m_cnt != 0));
    chk("R6", "ready", 32'(ready), 32'(m_rdy));
    chk("R7", "cause", 32'(cause), 32'(m_cause));
    chk("R8", "subsys_flag", 32'(sflag), 32'(m_flag));
    chk("R9", "enable", 32'(en_o), 32'(m_en));
    chk("R10", "page_shift", 32'(pshift), 32'(12 + m_mps));
    chk("R10", "mps_err", 32'(merr), 32'(m_err));
    chk("R9", "rdata", rdata, exp_rdata());
  endtask

  // one cycle: check at negedge, then drive new inputs
  task automatic cyc(logic w, logic [11:0] a, logic [31:0] d,
                     logic c = 0, logic l = 0, logic f = 0);
    @(negedge clk);
    check_all();
    we = w; addr = a; wdata = d; conv = c; link = l; fr = f;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 12'h014, 0);
  endtask

  int len;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R6", "reset ready", 32'(ready), 0);
    chk("R5", "reset core_rst", 32'(core_rst), 0);
    chk("R9", "reset cfg read", rdata, 0);
    rst_n = 1'b1;
    idle(2);
    // R4: rising enable causes no reset; R6 ready follows
    cyc(1, 12'h014, 32'h0000_0181);  // mps 3, en 1
    idle(3);
    chk("R4", "no reset on enable rise", 32'(core_rst), 0);
    chk("R6", "ready after enable", 32'(ready), 1);
    chk("R10", "page shift 15", 32'(pshift), 15);
    // R2: near-miss key and read of key register
    cyc(1, 12'h020, KEY ^ 32'h1);
    cyc(0, 12'h020, 0);
    chk("R2", "near-miss key", 32'({core_rst, sflag, cause}), 0);
    chk("R2", "key reg reads zero", rdata, 0);
    idle(1);
    // R4/R5: enable falling, count window length
    cyc(1, 12'h014, 32'h0);
    len = 0;
    for (int i = 0; i < W + 6; i++) begin cyc(0, 12'h014, 0); len += int'(core_rst); end
    chk("R5", "window length", 32'(len), W);
    chk("R7", "enable-fall cause", 32'(cause), 32'h10);
    // R5: extension by link-down late in window, plus R1 key
    cyc(1, 12'h014, 32'h1);
    cyc(1, 12'h020, KEY);
    len = 0;
    for (int i = 0; i < W + W + 8; i++) begin
      cyc(0, 12'h014, 0, 0, (i == W - 3), 0);
      len += int'(core_rst);
    end
    chk("R5", "extended window", 32'(len), 2 * W - 2);
    chk("R1", "flag set", 32'(sflag), 1);
    chk("R7", "link cause last", 32'(cause), 32'h4);
    // R10: invalid page size refused
    cyc(1, 12'h014, {21'b0, 4'd12, 6'b0, 1'b1});
    cyc(1, 12'h014, {21'b0, 4'd15, 6'b0, 1'b1});
    idle(1);
    chk("R10", "invalid mps refused", 32'(merr), 1);
    chk("R10", "shift kept", 32'(pshift), 12);
    // R3/R9: function reset collides with config write
    cyc(1, 12'h014, {21'b0, 4'd5, 6'b0, 1'b1}, 0, 0, 1);
    idle(1);
    chk("R3", "func reset", 32'(core_rst), 1);
    chk("R9", "cfg cleared", rdata, 0);
    idle(W + 2);
    // random phase
    for (int i = 0; i < 20000; i++) begin
      logic w; logic [11:0] a; logic [31:0] d;
      int r;
      r = $urandom_range(0, 99);
      w = r < 20;
      a = (r % 3 == 0) ? 12'h020 : ((r % 3 == 1) ? 12'h014 : 12'h01C);
      d = $urandom();
      if (a == 12'h020 && ($urandom_range(0, 3) == 0)) d = KEY;
      if (a == 12'h014) d[0] = ($urandom_range(0, 3) != 0);
      cyc(w, a, d, $urandom_range(0, 199) == 0,
          $urandom_range(0, 199) == 0, $urandom_range(0, 199) == 0);
    end
    idle(2);
    // R8: flag survives controller resets, clears on rst_ni
    chk("R8", "flag still set", 32'(sflag), 1);
    rst_n = 1'b0;
    #1;
    chk("R8", "flag cleared by rst_ni", 32'(sflag), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule